// File: doc/BRIEF.md
# Memory-Based Interrupt Status Writer

This block reports interrupts by writing bytes into memory instead of setting bits in registers. A number of reporting units each present a 16-bit event vector. An event bit that is enabled becomes one marker byte of value 0xFF in a status area, at an address derived from the unit number and the bit number. After all of a unit's status bytes are written, the block writes a marker byte for that unit into a source area. It then pulses a single interrupt line to the host. The host reads the source bytes to find which units need service and then reads each unit's 16 status bytes.

The enable word comes from memory and is presented to the block as an input. Events that arrive while a write sequence is running are held per unit and served later. The lowest-numbered pending unit is always served first. Writes go out through a byte-write port that holds each request until it is acknowledged.

Top module: `memirq_writer`

## Requirements
- R1: After reset, `wr_en` and `irq` are low and no write is issued until an enabled event arrives.
- R2: An enabled event on bit b of unit u produces a write of 0xFF to address `(stat_base & ~0xFFF) + 16*u + b`. The low 12 bits of `stat_base` are ignored.
- R3: An event pulse whose bit is clear in `en_mask` in the same cycle is dropped. It causes no write and no interrupt.
- R4: A unit's sequence writes its status bytes in ascending bit order. It then writes one 0xFF byte to `(src_base & ~0x3F) + u`. The low 6 bits of `src_base` are ignored.
- R5: `irq` is high for exactly one cycle, in the cycle after the source write is acknowledged. It is never high at any other time and never high together with `wr_en`.
- R6: A write request holds `wr_en`, `wr_addr` and `wr_data` unchanged until `wr_ack` is sampled high.
- R7: Events that arrive during a sequence are held and served later. When several units are pending, the lowest unit number is served first.
- R8: Repeated pulses of the same bit while that bit is still pending merge into a single status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NUNITS*16 | Per-unit event pulses, unit u in bits [16u+15:16u] |
| en_mask | input | 16 | Enable word read from the mask location |
| stat_base | input | AW | Status area base, 4 KiB aligned by the block |
| src_base | input | AW | Source area base, 64-byte aligned by the block |
| wr_en | output | 1 | Byte write request |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data (always 0xFF) |
| wr_ack | input | 1 | Write accepted at this clock edge |
| irq | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The first status write of a sequence appears at the earliest one cycle after the event edge. This is because the event is first registered as pending. Each later write appears in the cycle after the previous acknowledge, and `irq` is due exactly one cycle after the source write's acknowledge. The bench logs every write at the falling edge before the edge that accepts it. It requires `irq` in the very next sampled cycle after the source write and forbids it in every other cycle. Per-unit sets of reported bits are compared with the enabled injected bits only after the port has been quiet for many cycles, so no result depends on the random acknowledge latency.

// File: rtl/memirq_writer.sv
module memirq_writer #(
  parameter int NUNITS = 8,
  parameter int AW     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUNITS-1:0][15:0] evt,
  input  logic [15:0]            en_mask,
  input  logic [AW-1:0]          stat_base,
  input  logic [AW-1:0]          src_base,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [7:0]             wr_data,
  input  logic                   wr_ack,
  output logic                   irq
);
  localparam int UW = (NUNITS > 1) ? $clog2(NUNITS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_STAT, S_SRC, S_IRQ} st_t;

  st_t                   st;
  logic [NUNITS-1:0][15:0] pend;
  logic [NUNITS-1:0][15:0] new_ev;
  logic [15:0]           work;
  logic [UW-1:0]         cur_u, nxt_u;
  logic [3:0]            cur_b;
  logic                  any_pend;
  logic [AW-1:0]         stat_al, src_al;

  assign stat_al = {stat_base[AW-1:12], 12'h000};
  assign src_al  = {src_base[AW-1:6], 6'h00};

  always_comb begin
    for (int i = 0; i < NUNITS; i++) new_ev[i] = evt[i] & en_mask;
  end

  always_comb begin
    nxt_u    = '0;
    any_pend = 1'b0;
    for (int i = NUNITS - 1; i >= 0; i--) begin
      if (|pend[i]) begin
        nxt_u    = UW'(i);
        any_pend = 1'b1;
      end
    end
  end

  always_comb begin
    cur_b = '0;
    for (int i = 15; i >= 0; i--) if (work[i]) cur_b = 4'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= '0;
      work  <= '0;
      cur_u <= '0;
    end else begin
      for (int i = 0; i < NUNITS; i++) pend[i] <= pend[i] | new_ev[i];
      case (st)
        S_IDLE: if (any_pend) begin
          work        <= pend[nxt_u];
          cur_u       <= nxt_u;
          pend[nxt_u] <= new_ev[nxt_u];
          st          <= S_STAT;
        end
        S_STAT: if (wr_ack) begin
          work[cur_b] <= 1'b0;
          if ((work & ~(16'h0001 << cur_b)) == 16'h0000) st <= S_SRC;
        end
        S_SRC: if (wr_ack) st <= S_IRQ;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_en   = (st == S_STAT) || (st == S_SRC);
  assign wr_data = 8'hFF;
  assign wr_addr = (st == S_SRC) ? src_al + AW'(cur_u)
                                 : stat_al + AW'({cur_u, cur_b});
  assign irq     = (st == S_IRQ);
endmodule

// File: rtl/memirq_writer_chk.sv
module memirq_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_ack,
  input logic          irq
);
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ack) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

  a_r2_marker_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == 8'hFF));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !wr_en);

  a_r5_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en && wr_ack));
endmodule

bind memirq_writer memirq_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
);

// File: tb/memirq_writer_test.sv
module memirq_writer_test;
  localparam int NU = 8;
  localparam int AW = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NU-1:0][15:0] evt = '0;
  logic [15:0]        en_mask = 16'hFFFF;
  logic [AW-1:0]      stat_base = 32'h0002_3ABC;
  logic [AW-1:0]      src_base  = 32'h0004_05C7;
  logic               wr_en, wr_ack = 1'b0, irq;
  logic [AW-1:0]      wr_addr;
  logic [7:0]         wr_data;

  int total = 0, bad = 0;
  bit ack_on = 1'b1;
  logic [NU-1:0][15:0] inj, rep;
  int cnt [NU][16];
  int order [64];
  int n_order = 0;
  bit in_seq = 0, exp_irq = 0;
  int seq_u = 0, last_b = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  memirq_writer #(.NUNITS(NU), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en_mask(en_mask),
    .stat_base(stat_base), .src_base(src_base), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq));

  function automatic logic [AW-1:0] stat_al();
    return stat_base & ~32'hFFF;
  endfunction
  function automatic logic [AW-1:0] src_al();
    return src_base & ~32'h3F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory responder and write monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq == exp_irq, "R5 irq timing", irq, exp_irq);
      exp_irq = 0;
      if (wr_en && ack_on && ($urandom_range(0, 9) < 6)) begin
        wr_ack <= 1'b1;
        chk(wr_data == 8'hFF, "R2 data", wr_data, 8'hFF);
        if (wr_addr >= stat_al() && wr_addr < stat_al() + NU * 16) begin
          int u, b;
          u = int'(wr_addr - stat_al()) / 16;
          b = int'(wr_addr - stat_al()) % 16;
          chk(!in_seq || (u == seq_u && b > last_b), "R4 bit order", b, last_b + 1);
          in_seq = 1; seq_u = u; last_b = b;
          rep[u][b] = 1'b1;
          cnt[u][b]++;
        end else if (wr_addr >= src_al() && wr_addr < src_al() + NU) begin
          int u;
          u = int'(wr_addr - src_al());
          chk(in_seq && u == seq_u, "R4 source after status", u, seq_u);
          if (n_order < 64) order[n_order] = u;
          n_order++;
          in_seq = 0; last_b = -1;
          exp_irq = 1;
        end else begin
          chk(0, "R2 address in area", wr_addr, stat_al());
        end
      end else begin
        wr_ack <= 1'b0;
      end
    end
  end

  task automatic clear_log();
    inj = '0; rep = '0; n_order = 0;
    for (int u = 0; u < NU; u++) for (int b = 0; b < 16; b++) cnt[u][b] = 0;
  endtask

  task automatic fire(input int u, input int b, input logic [15:0] m);
    @(negedge clk);
    evt = '0;
    evt[u][b] = 1'b1;
    en_mask = m;
    if (m[b]) inj[u][b] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (wr_en || irq) q = 0; else q++;
    end
  endtask

  task automatic compare_sets(input string req);
    for (int u = 0; u < NU; u++) chk(rep[u] == inj[u], req, rep[u], inj[u]);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    clear_log();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    repeat (10) @(negedge clk);
    chk(wr_en == 1'b0, "R1 no write while idle", wr_en, 0);

    // R2/R4/R5: single event, exact address
    clear_log();
    fire(3, 9, 16'hFFFF);
    wait_quiet();
    chk(cnt[3][9] == 1, "R2 unit3 bit9 written once", cnt[3][9], 1);
    chk(n_order == 1 && order[0] == 3, "R4 one source write unit3", order[0], 3);
    compare_sets("R2 single event set");

    // R3: masked-off events dropped
    clear_log();
    fire(1, 4, 16'h0000);
    fire(6, 0, 16'hFFFE);
    wait_quiet();
    chk(n_order == 0, "R3 masked event no sequence", n_order, 0);
    compare_sets("R3 masked set empty");

    // R7: ascending unit order while busy
    clear_log();
    ack_on = 0;
    fire(6, 0, 16'hFFFF);
    fire(5, 2, 16'hFFFF);
    fire(1, 7, 16'hFFFF);
    fire(4, 15, 16'hFFFF);
    repeat (3) @(negedge clk);
    ack_on = 1;
    wait_quiet();
    chk(n_order == 4, "R7 four sequences", n_order, 4);
    chk(order[0] == 6, "R7 first is in-flight unit", order[0], 6);
    chk(order[1] == 1, "R7 lowest pending next", order[1], 1);
    chk(order[2] == 4, "R7 then unit4", order[2], 4);
    chk(order[3] == 5, "R7 then unit5", order[3], 5);
    compare_sets("R7 all held events served");

    // R8: duplicate pulses merge
    clear_log();
    ack_on = 0;
    fire(0, 1, 16'hFFFF);
    fire(2, 4, 16'hFFFF);
    fire(2, 4, 16'hFFFF);
    fire(2, 11, 16'hFFFF);
    ack_on = 1;
    wait_quiet();
    chk(cnt[2][4] == 1, "R8 merged write count", cnt[2][4], 1);
    chk(cnt[2][11] == 1, "R8 other bit in same sequence", cnt[2][11], 1);
    compare_sets("R8 set");

    // R6 covered by checker; random rounds for R2..R7
    for (int r = 0; r < 30; r++) begin
      logic [15:0] m;
      clear_log();
      case (r % 3)
        0: m = 16'hFFFF;
        1: m = 16'(($urandom()));
        default: m = (r % 2) ? 16'h0000 : 16'h00F0;
      endcase
      if (r == 10) begin stat_base = 32'h0010_0FFF; src_base = 32'h0020_003F; end
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        en_mask = m;
        for (int u = 0; u < NU; u++) begin
          evt[u] = ($urandom_range(0, 3) == 0) ? 16'(($urandom())) & 16'(($urandom())) : 16'h0;
          inj[u] = inj[u] | (evt[u] & m);
        end
      end
      @(negedge clk);
      evt = '0;
      wait_quiet();
      compare_sets("R2 R3 R7 random round");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule